// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control core of a 10-bit successive-approximation converter. A host writes a 10-bit control word through an active-low chip-select and write strobe. The end of the write strobe loads the word and starts a conversion sequence. The strobe comes from an asynchronous host bus, so the core brings it into its own clock domain before it acts on it. A sequence has three parts. First comes a fixed acquisition window. Then the hold control rises and the core makes a binary search over a trial code driven on `dac_code_o`. An external comparator answers each trial through `cmp_i`.

The sequence can convert one channel, or two channels that were acquired together and are then converted one after the other. Each result is stored in its own result register, and the host reads the results back with a read strobe. One active-low status pin reports the conversion state. It has two modes: low while a sequence runs, or low from the end of a sequence until the host next accesses the block. A write during a running sequence aborts it. Setting the power-down bit stops the core. In half-scale test mode the core converts the reference in place of the selected inputs.

Top module: `sar_seq_top`

## Requirements
- R1: After reset the control word is all zeros, `busy_int_no` is 1, and `data_o`, `dac_code_o`, `hold_o`, `chan_o`, `half_scale_o` and `power_down_o` are all 0.
- R2: The control word is loaded from `data_i` when the combined strobe (`cs_ni` and `wr_ni` both low) ends. `data_i` must stay stable for at least 3 clocks after the strobe ends. The field layout is: bits 2:0 first channel, bits 5:3 second channel, bit 6 double conversion (1) or single (0), bit 7 half-scale test, bit 8 power-down, bit 9 flag mode (0 busy level, 1 done interrupt).
- R3: A write with bit 8 clear starts a sequence: 4 acquisition cycles with `hold_o` low, then one 14-cycle conversion per channel with `hold_o` high. In busy mode the flag is therefore low for exactly 18 cycles in single mode and 32 cycles in double mode.
- R4: A comparator value of 1 keeps the trial bit. The stored result is in two's complement: the final search code with bit 9 inverted. An input equal to code v therefore reads back as v XOR 0x200.
- R5: Each conversion begins with trial code 0x200 (MSB first). The MSB is decided after 2 settling cycles plus 2 cycles, and each lower bit is decided on one clock edge.
- R6: In busy mode (bit 9 = 0), `busy_int_no` is low from the load until the last conversion of the sequence has transferred its result.
- R7: In double mode, `chan_o` shows the first channel field during the first conversion and the second field during the second conversion. The results go to result register 1 and result register 2 in that order. The flag does not change between the two conversions.
- R8: A read strobe (`cs_ni` and `rd_ni` low) presents a result on `data_o`. In single mode every read returns result register 1. In double mode the reads alternate, 1, 2, 1, ..., and the sequence restarts at register 1 after every write.
- R9: With bit 7 set, the reference is converted (`half_scale_o` = 1) whatever the channel fields hold, and bit 6 still selects one or two conversions.
- R10: In interrupt mode (bit 9 = 1), `busy_int_no` stays high during the sequence. It goes low one cycle after the last result is stored, and stays low until the start of the next read or write strobe.
- R11: The start of a write strobe during a sequence aborts the sequence and drives the flag high. When the strobe ends, a full new sequence runs as set by the new bit 6.
- R12: A write with bit 8 set stops any sequence, sets `power_down_o`, keeps the flag high and keeps `hold_o` low. Both result registers keep their contents and can still be read.
- R13: A later write with bit 8 clear leaves power-down and starts a new sequence whose results overwrite the stored ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low, asynchronous |
| wr_ni | input | 1 | Write strobe, active low, asynchronous |
| rd_ni | input | 1 | Read strobe, active low, asynchronous |
| data_i | input | 10 | Control word written by the host |
| cmp_i | input | 1 | Comparator result: 1 when the input is at or above the trial code |
| data_o | output | 10 | Selected result register, two's complement |
| busy_int_no | output | 1 | Active-low status flag (busy level or done interrupt) |
| dac_code_o | output | 10 | Trial code for the DAC |
| hold_o | output | 1 | Track/hold control, 1 = hold |
| chan_o | output | 3 | Channel currently acquired or converted |
| half_scale_o | output | 1 | Reference selected as the conversion input |
| power_down_o | output | 1 | Analog circuitry powered down |

## Verification
On every cycle, the assertions check that the hold control only rises out of the acquisition phase and that it rises with the MSB trial code. They also check three things: a second pass happens only when double mode is set; result register 2 changes only from a second pass; and, in interrupt mode, the flag falls only right after a sequence finishes. In power-down they check that the flag stays high and that no acquisition or hold takes place. Only the directed scenarios can show the rest: the exact flag-low window length, the result codes for particular comparator answers, the alternating readback order, and the effect of the half-scale and abort rules. They also show that results stored before power-down survive it and are replaced after it ends.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int DW   = 10;
  localparam int CH_W = 3;

  // Field order is the write-data bit order (sel_a at bit 0)
  typedef struct packed {
    logic            int_mode;
    logic            pwr_dn;
    logic            half;
    logic            dbl;
    logic [CH_W-1:0] sel_b;
    logic [CH_W-1:0] sel_a;
  } ctrl_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ACQ  = 2'd1,
    PH_CONV = 2'd2
  } phase_e;
endpackage

// File: rtl/sar_strobe_sync.sv
module sar_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], strobe_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/sar_ctrl_reg.sv
module sar_ctrl_reg
  import sar_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  output ctrl_t         ctrl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ctrl_o <= '0;
    else if (load_i) ctrl_o <= ctrl_t'(data_i);
  end
endmodule

// File: rtl/sar_engine.sv
module sar_engine
  import sar_pkg::*;
#(
  parameter int ACQ_CYC    = 4,
  parameter int SETTLE_CYC = 2,
  parameter int MSB_CYC    = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            abort_i,
  input  ctrl_t           ctrl_i,
  input  logic            cmp_i,
  output logic            active_o,
  output logic            acq_o,
  output logic            hold_o,
  output logic            pass_o,
  output logic            wr1_o,
  output logic            wr2_o,
  output logic            done_o,
  output logic [CH_W-1:0] chan_o,
  output logic [DW-1:0]   dac_code_o,
  output logic [DW-1:0]   result_o
);
  localparam int FIRST_DEC = SETTLE_CYC + MSB_CYC - 1;
  localparam int LAST_DEC  = FIRST_DEC + DW - 1;
  localparam int XFER      = LAST_DEC + 1;
  localparam int CNT_MAX   = (XFER > ACQ_CYC) ? XFER : ACQ_CYC;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);
  localparam int BI_W      = $clog2(DW);

  phase_e          phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pass_q;
  logic [DW-1:0]    sar_q;
  logic [BI_W-1:0]  bidx_q;
  logic             dec, xfer, trial_on;

  assign dec      = (phase_q == PH_CONV) && (cnt_q >= CNT_W'(FIRST_DEC)) && (cnt_q <= CNT_W'(LAST_DEC));
  assign xfer     = (phase_q == PH_CONV) && (cnt_q == CNT_W'(XFER));
  assign trial_on = (phase_q == PH_CONV) && (cnt_q <= CNT_W'(LAST_DEC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      pass_q  <= 1'b0;
      sar_q   <= '0;
      bidx_q  <= BI_W'(DW-1);
    end else if (abort_i) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      pass_q  <= 1'b0;
    end else if (start_i) begin
      phase_q <= PH_ACQ;
      cnt_q   <= '0;
      pass_q  <= 1'b0;
    end else begin
      case (phase_q)
        PH_ACQ: begin
          if (cnt_q == CNT_W'(ACQ_CYC-1)) begin
            phase_q <= PH_CONV;
            cnt_q   <= '0;
            sar_q   <= '0;
            bidx_q  <= BI_W'(DW-1);
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_CONV: begin
          if (dec) begin
            sar_q[bidx_q] <= cmp_i;
            if (bidx_q != '0) bidx_q <= bidx_q - 1'b1;
          end
          if (xfer) begin
            cnt_q <= '0;
            if (ctrl_i.dbl && !pass_q) begin
              pass_q <= 1'b1;
              sar_q  <= '0;
              bidx_q <= BI_W'(DW-1);
            end else begin
              phase_q <= PH_IDLE;
              pass_q  <= 1'b0;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign active_o   = (phase_q != PH_IDLE);
  assign acq_o      = (phase_q == PH_ACQ);
  assign hold_o     = (phase_q == PH_CONV);
  assign pass_o     = pass_q;
  assign wr1_o      = xfer && !pass_q;
  assign wr2_o      = xfer && pass_q;
  assign done_o     = xfer && (pass_q || !ctrl_i.dbl);
  assign chan_o     = pass_q ? ctrl_i.sel_b : ctrl_i.sel_a;
  assign dac_code_o = sar_q | (trial_on ? (DW'(1) << bidx_q) : '0);
  assign result_o   = {~sar_q[DW-1], sar_q[DW-2:0]};
endmodule

// File: rtl/sar_results.sv
module sar_results
  import sar_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr1_i,
  input  logic          wr2_i,
  input  logic [DW-1:0] result_i,
  input  logic          dbl_i,
  input  logic          wr_end_i,
  input  logic          rd_end_i,
  output logic [DW-1:0] res1_o,
  output logic [DW-1:0] res2_o,
  output logic [DW-1:0] data_o
);
  logic rptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res1_o <= '0;
      res2_o <= '0;
      rptr_q <= 1'b0;
    end else begin
      if (wr1_i) res1_o <= result_i;
      if (wr2_i) res2_o <= result_i;
      if (wr_end_i)      rptr_q <= 1'b0;
      else if (rd_end_i) rptr_q <= dbl_i ? ~rptr_q : 1'b0;
    end
  end

  assign data_o = rptr_q ? res2_o : res1_o;
endmodule

// File: rtl/sar_flag.sv
module sar_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic int_mode_i,
  input  logic active_i,
  input  logic done_i,
  input  logic wr_start_i,
  input  logic rd_start_i,
  output logic flag_no
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      pend_q <= 1'b0;
    else if (wr_start_i || rd_start_i) pend_q <= 1'b0;
    else if (done_i)                   pend_q <= 1'b1;
  end

  assign flag_no = int_mode_i ? ~pend_q : ~active_i;
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
  import sar_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ACQ_CYC     = 4,
  parameter int SETTLE_CYC  = 2,
  parameter int MSB_CYC     = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cs_ni,
  input  logic            wr_ni,
  input  logic            rd_ni,
  input  logic [DW-1:0]   data_i,
  input  logic            cmp_i,
  output logic [DW-1:0]   data_o,
  output logic            busy_int_no,
  output logic [DW-1:0]   dac_code_o,
  output logic            hold_o,
  output logic [CH_W-1:0] chan_o,
  output logic            half_scale_o,
  output logic            power_down_o
);
  logic    wr_start, wr_end, rd_start, rd_end, start;
  ctrl_t   ctrl, wdat;
  logic    eng_active, eng_acq, eng_pass, eng_wr1, eng_wr2, eng_done;
  logic [DW-1:0] eng_result, res1, res2;

  sar_strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(~cs_ni & ~wr_ni),
    .rise_o(wr_start), .fall_o(wr_end)
  );

  sar_strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(~cs_ni & ~rd_ni),
    .rise_o(rd_start), .fall_o(rd_end)
  );

  sar_ctrl_reg u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(wr_end), .data_i(data_i), .ctrl_o(ctrl)
  );

  assign wdat  = ctrl_t'(data_i);
  assign start = wr_end & ~wdat.pwr_dn;

  sar_engine #(.ACQ_CYC(ACQ_CYC), .SETTLE_CYC(SETTLE_CYC), .MSB_CYC(MSB_CYC)) u_eng (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .abort_i(wr_start),
    .ctrl_i(ctrl), .cmp_i(cmp_i),
    .active_o(eng_active), .acq_o(eng_acq), .hold_o(hold_o), .pass_o(eng_pass),
    .wr1_o(eng_wr1), .wr2_o(eng_wr2), .done_o(eng_done),
    .chan_o(chan_o), .dac_code_o(dac_code_o), .result_o(eng_result)
  );

  sar_results u_res (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr1_i(eng_wr1), .wr2_i(eng_wr2),
    .result_i(eng_result), .dbl_i(ctrl.dbl), .wr_end_i(wr_end), .rd_end_i(rd_end),
    .res1_o(res1), .res2_o(res2), .data_o(data_o)
  );

  sar_flag u_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .int_mode_i(ctrl.int_mode), .active_i(eng_active),
    .done_i(eng_done), .wr_start_i(wr_start), .rd_start_i(rd_start), .flag_no(busy_int_no)
  );

  assign half_scale_o = ctrl.half;
  assign power_down_o = ctrl.pwr_dn;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk
  import sar_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_int_ni,
  input logic          power_down_i,
  input logic          hold_i,
  input logic          acq_i,
  input logic          pass_i,
  input logic          done_i,
  input logic          int_mode_i,
  input logic          dbl_i,
  input logic [DW-1:0] dac_code_i,
  input logic [DW-1:0] res2_i
);
  // R5
  msb_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_i) |-> dac_code_i == (DW'(1) << (DW-1)));

  // R3
  acq_before_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_i) |-> $past(acq_i));

  // R7
  second_pass_dbl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pass_i) |-> dbl_i);

  // R7
  res2_from_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(res2_i) |-> $past(pass_i && hold_i));

  // R10
  int_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_mode_i && $fell(busy_int_ni)) |-> $past(done_i));

  // R12
  pd_flag_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    power_down_i |-> busy_int_ni);

  // R12
  pd_no_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    power_down_i |-> (!hold_i && !acq_i));
endmodule

bind sar_seq_top sar_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_int_ni(busy_int_no), .power_down_i(power_down_o),
  .hold_i(hold_o), .acq_i(eng_acq), .pass_i(eng_pass), .done_i(eng_done),
  .int_mode_i(ctrl.int_mode), .dbl_i(ctrl.dbl), .dac_code_i(dac_code_o), .res2_i(res2)
);

// File: tb/tb_sar_seq_top.sv
module tb_sar_seq_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_ni = 1'b1, wr_ni = 1'b1, rd_ni = 1'b1;
  logic [9:0] data_i = '0;
  logic       cmp_i;
  logic [9:0] data_o, dac_code_o;
  logic       busy_int_no, hold_o, half_scale_o, power_down_o;
  logic [2:0] chan_o;

  int total = 0, bad = 0, lowc = 0;

  always #2.5 clk_i = ~clk_i;

  sar_seq_top dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .wr_ni(wr_ni), .rd_ni(rd_ni),
    .data_i(data_i), .cmp_i(cmp_i), .data_o(data_o), .busy_int_no(busy_int_no),
    .dac_code_o(dac_code_o), .hold_o(hold_o), .chan_o(chan_o),
    .half_scale_o(half_scale_o), .power_down_o(power_down_o)
  );

  function automatic int vin(input logic [2:0] c);
    case (c)
      3'd0: vin = 0;    3'd1: vin = 100;  3'd2: vin = 250;  3'd3: vin = 700;
      3'd4: vin = 333;  3'd5: vin = 512;  3'd6: vin = 900;  default: vin = 1023;
    endcase
  endfunction

  // comparator model: 1 when input >= trial code
  always_comb cmp_i = (int'(dac_code_o) <= (half_scale_o ? 512 : vin(chan_o)));

  function automatic int tc(input int v);
    tc = v ^ 512;
  endfunction

  function automatic logic [9:0] cw(input bit im, input bit pd, input bit hs, input bit db,
                                    input int b, input int a);
    cw = {im, pd, hs, db, 3'(b), 3'(a)};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
    if (!busy_int_no) lowc++;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr_cfg(input logic [9:0] d, input bit chk_flag);
    data_i = d; cs_ni = 1'b0; tick();
    wr_ni = 1'b0; ticks(4);
    if (chk_flag) check("R11 flag high during write", busy_int_no, 1);
    wr_ni = 1'b1; lowc = 0; ticks(4);
    cs_ni = 1'b1; tick();
  endtask

  task automatic rd_res(output int v);
    cs_ni = 1'b0; tick();
    rd_ni = 1'b0; ticks(4);
    v = data_o;
    rd_ni = 1'b1; ticks(4);
    cs_ni = 1'b1; tick();
  endtask

  task automatic wait_high();
    int n = 0;
    while (!busy_int_no && n < 200) begin tick(); n++; end
    if (n >= 200) check("watchdog flag release", 0, 1);
  endtask

  task automatic t_reset();
    check("R1 flag", busy_int_no, 1);
    check("R1 data", data_o, 0);
    check("R1 dac", dac_code_o, 0);
    check("R1 hold", hold_o, 0);
    check("R1 chan", chan_o, 0);
    check("R1 half", half_scale_o, 0);
    check("R1 pd", power_down_o, 0);
  endtask

  task automatic t_single();
    int v;
    wr_cfg(cw(0, 0, 0, 0, 5, 3), 0);
    check("R6 flag low while running", busy_int_no, 0);
    wait_high();
    check("R3 single busy window", lowc, 18);
    rd_res(v); check("R2 R4 single ch3 result", v, tc(700));
    rd_res(v); check("R8 single repeat read", v, tc(700));
    wr_cfg(cw(0, 0, 0, 0, 0, 0), 0); wait_high();
    rd_res(v); check("R4 zero input", v, tc(0));
    wr_cfg(cw(0, 0, 0, 0, 0, 7), 0); wait_high();
    rd_res(v); check("R4 full input", v, tc(1023));
  endtask

  task automatic t_double();
    int v;
    bit saw_a = 0, saw_b = 0;
    wr_cfg(cw(0, 0, 0, 1, 6, 1), 0);
    while (!busy_int_no) begin
      if (hold_o && chan_o == 3'd1) saw_a = 1;
      if (hold_o && chan_o == 3'd6) saw_b = 1;
      tick();
    end
    check("R3 R6 double busy window", lowc, 32);
    check("R7 first channel converted", saw_a, 1);
    check("R7 second channel converted", saw_b, 1);
    rd_res(v); check("R8 first read reg1", v, tc(100));
    rd_res(v); check("R8 second read reg2", v, tc(900));
    rd_res(v); check("R8 third read reg1", v, tc(100));
  endtask

  task automatic t_half();
    int v;
    wr_cfg(cw(0, 0, 1, 1, 4, 7), 0);
    check("R9 half-scale select", half_scale_o, 1);
    wait_high();
    check("R9 double still two passes", lowc, 32);
    rd_res(v); check("R9 reg1 reference", v, 0);
    rd_res(v); check("R9 reg2 reference", v, 0);
  endtask

  task automatic t_int();
    int v;
    bit stay = 1;
    int n = 0;
    wr_cfg(cw(1, 0, 0, 0, 0, 2), 0);
    check("R10 flag high while running", busy_int_no, 1);
    while (busy_int_no && n < 200) begin tick(); n++; end
    check("R10 flag fell after conversion", busy_int_no, 0);
    for (int i = 0; i < 10; i++) begin tick(); if (busy_int_no) stay = 0; end
    check("R10 flag stays low", stay, 1);
    rd_res(v);
    check("R10 read result", v, tc(250));
    check("R10 read clears flag", busy_int_no, 1);
  endtask

  task automatic t_abort();
    int v;
    wr_cfg(cw(0, 0, 0, 1, 6, 1), 0);
    ticks(6);
    check("R11 running before abort", busy_int_no, 0);
    wr_cfg(cw(0, 0, 0, 0, 0, 7), 1);
    wait_high();
    check("R11 full new sequence", lowc, 18);
    rd_res(v); check("R11 new result", v, tc(1023));
  endtask

  task automatic t_pd();
    int v;
    bit no_hold = 1;
    wr_cfg(cw(0, 0, 0, 1, 4, 2), 0); wait_high();
    wr_cfg(cw(0, 0, 0, 1, 6, 1), 0);
    ticks(6);
    wr_cfg(cw(0, 1, 0, 1, 6, 1), 0);
    check("R12 power-down out", power_down_o, 1);
    for (int i = 0; i < 40; i++) begin
      tick();
      if (hold_o || !busy_int_no) no_hold = 0;
    end
    check("R12 idle and flag high", no_hold, 1);
    rd_res(v); check("R12 reg1 kept", v, tc(250));
    rd_res(v); check("R12 reg2 kept", v, tc(333));
    wr_cfg(cw(0, 0, 0, 1, 6, 1), 0);
    check("R13 power-down cleared", power_down_o, 0);
    wait_high();
    check("R13 restart runs", lowc, 32);
    rd_res(v); check("R13 reg1 overwritten", v, tc(100));
    rd_res(v); check("R13 reg2 overwritten", v, tc(900));
  endtask

  initial begin
    fork
      begin
        ticks(3);
        t_reset();
        rst_ni = 1'b1;
        ticks(2);
        t_reset();
        t_single();
        t_double();
        t_half();
        t_int();
        t_abort();
        t_pd();
      end
      begin
        repeat (150000) @(posedge clk_i);
        check("watchdog expired", 0, 1);
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule